// File: doc/BRIEF.md
# Stretchable External Memory Bus Sequencer

This block carries out a single read or write to external data memory over a bus whose address and data lines are separate. A requester presents a direction flag, an address and write data, together with a 3-bit stretch code. The block samples everything at acceptance, then moves through three timed phases: an address/chip-enable lead, an active-low strobe, and a tail during which the chip enable (and, for writes, the data drive) is held. When the access ends it pulses a one-cycle completion flag. For reads, the data captured at the end of the strobe is presented on that same cycle.

The stretch code sets the timing. The strobe width grows in direct proportion to the code. The lead and the tail move in three steps: code zero, codes one to three, and codes four to seven. All timing is counted in whole clock cycles. The reset is asynchronous and active-low, and its release passes through a two-stage synchronizer.

Top module: `ext_mem_seq`

## Requirements
- R1: A request is taken only when `req_ready` is high, and `req_ready` is high only while no access is in flight. A request raised while busy has no effect: no address change and no second access.
- R2: During and after reset, and whenever idle, the outputs are at rest: `bus_rd_n`, `bus_wr_n` and `bus_ce_n` are high and `bus_dout_oe` is low. An asynchronous reset in mid-access releases the strobe at once.
- R3: `bus_ce_n` is low and `bus_addr` holds the request address for a lead of 1 cycle (code 0), 2 cycles (codes 1-3) or 10 cycles (codes 4-7) before the strobe falls.
- R4: The strobe stays low for 2 cycles at code 0, and for 4 x code cycles at codes 1-7.
- R5: After the strobe rises, `bus_ce_n` stays low for 1, 2 or 6 more cycles (codes 0, 1-3, 4-7). It then goes high.
- R6: A write uses only `bus_wr_n`. `bus_dout_oe` is high and `bus_dout` equals the write data for the whole time `bus_ce_n` is low, which covers the lead before the strobe and the 1/2/6-cycle hold after it. A read uses only `bus_rd_n` and never enables the data drive.
- R7: `done` is high for exactly one cycle, the first cycle in which `bus_ce_n` is high again. On a read, `rdata` then carries the `bus_din` value sampled on the last strobe cycle, even though `bus_din` has changed since.
- R8: The stretch code is sampled at acceptance. Changing `stretch_cfg` during an access does not alter its timing.
- R9: `req_ready` is high in the same cycle as `done`. A request held high then starts the next access, and its lead begins on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stretch_cfg | input | STR_W | Stretch code, sampled at acceptance |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Memory address |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | DATA_W | Write data to memory |
| bus_dout_oe | output | 1 | Write data output enable |
| bus_din | input | DATA_W | Read data from memory |

## Verification
The completion pulse of one access and the acceptance of the next can fall in the same cycle. This happens because the block goes back to idle and raises `done` together. The bench provokes the collision by holding `req_valid` high across the end of a write. In the cycle where `done` is seen, it requires `req_ready` to be high, and it requires a new chip-enable lead to start on the very next cycle. The complementary case is a request held high during a busy access and dropped before completion. There the bench requires that the address stays fixed and that no further access follows.

// File: rtl/ems_pkg.sv
package ems_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } ems_state_e;
endpackage

// File: rtl/ems_rst_sync.sv
module ems_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/ems_phase_len.sv
module ems_phase_len #(
  parameter int STR_W       = 3,
  parameter int CNT_W       = 5,
  parameter int TIER1_MAX   = 3,
  parameter int SETUP_T0    = 1,
  parameter int SETUP_T1    = 2,
  parameter int SETUP_T2    = 10,
  parameter int TAIL_T0     = 1,
  parameter int TAIL_T1     = 2,
  parameter int TAIL_T2     = 6,
  parameter int STROBE_BASE = 2,
  parameter int STROBE_MULT = 4
) (
  input  logic [STR_W-1:0] stretch,
  output logic [CNT_W-1:0] setup_len,
  output logic [CNT_W-1:0] strobe_len,
  output logic [CNT_W-1:0] tail_len
);
  logic is_zero;
  logic is_low;

  always_comb begin
    is_zero = (stretch == '0);
    is_low  = (int'(stretch) <= TIER1_MAX);
    if (is_zero) begin
      setup_len  = CNT_W'(SETUP_T0);
      tail_len   = CNT_W'(TAIL_T0);
      strobe_len = CNT_W'(STROBE_BASE);
    end else begin
      setup_len  = is_low ? CNT_W'(SETUP_T1) : CNT_W'(SETUP_T2);
      tail_len   = is_low ? CNT_W'(TAIL_T1)  : CNT_W'(TAIL_T2);
      strobe_len = CNT_W'(STROBE_MULT) * CNT_W'(stretch);
    end
  end
endmodule

// File: rtl/ems_phase_cnt.sv
module ems_phase_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = clr ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ems_ctrl.sv
module ems_ctrl
  import ems_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] setup_len,
  input  logic [CNT_W-1:0] strobe_len,
  input  logic [CNT_W-1:0] tail_len,
  input  logic [CNT_W-1:0] cnt,
  output ems_state_e       state_q,
  output logic             accept,
  output logic             cnt_clr,
  output logic             capture,
  output logic             done_q
);
  ems_state_e       state_d;
  logic [CNT_W-1:0] phase_len;
  logic             phase_last;
  logic             done_d;

  always_comb begin
    phase_len = setup_len;
    case (state_q)
      ST_STROBE: phase_len = strobe_len;
      ST_HOLD:   phase_len = tail_len;
      default:   phase_len = setup_len;
    endcase
    phase_last = (state_q != ST_IDLE) && (cnt == phase_len - CNT_W'(1));
    accept     = (state_q == ST_IDLE) && req_valid;
    cnt_clr    = accept || phase_last;
    capture    = (state_q == ST_STROBE) && phase_last;
    done_d     = (state_q == ST_HOLD) && phase_last;

    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept)     state_d = ST_SETUP;
      ST_SETUP:  if (phase_last) state_d = ST_STROBE;
      ST_STROBE: if (phase_last) state_d = ST_HOLD;
      ST_HOLD:   if (phase_last) state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
  import ems_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int STR_W       = 3,
  parameter int TIER1_MAX   = 3,
  parameter int SETUP_T0    = 1,
  parameter int SETUP_T1    = 2,
  parameter int SETUP_T2    = 10,
  parameter int TAIL_T0     = 1,
  parameter int TAIL_T1     = 2,
  parameter int TAIL_T2     = 6,
  parameter int STROBE_BASE = 2,
  parameter int STROBE_MULT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STR_W-1:0]  stretch_cfg,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ce_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_oe,
  input  logic [DATA_W-1:0] bus_din
);
  localparam int STR_MAX    = (1 << STR_W) - 1;
  localparam int MAX_STROBE = STROBE_MULT * STR_MAX;
  localparam int MAX_A      = (MAX_STROBE > SETUP_T2) ? MAX_STROBE : SETUP_T2;
  localparam int MAX_B      = (TAIL_T2 > STROBE_BASE) ? TAIL_T2 : STROBE_BASE;
  localparam int MAX_LEN    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W      = $clog2(MAX_LEN + 1);

  logic              rst_q_n;
  ems_state_e        state_q;
  logic              accept;
  logic              cnt_clr;
  logic              capture;
  logic              cnt_en;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  setup_len;
  logic [CNT_W-1:0]  strobe_len;
  logic [CNT_W-1:0]  tail_len;
  logic [STR_W-1:0]  stretch_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  ems_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ems_phase_len #(
    .STR_W(STR_W), .CNT_W(CNT_W), .TIER1_MAX(TIER1_MAX),
    .SETUP_T0(SETUP_T0), .SETUP_T1(SETUP_T1), .SETUP_T2(SETUP_T2),
    .TAIL_T0(TAIL_T0), .TAIL_T1(TAIL_T1), .TAIL_T2(TAIL_T2),
    .STROBE_BASE(STROBE_BASE), .STROBE_MULT(STROBE_MULT)
  ) u_len (
    .stretch    (stretch_q),
    .setup_len  (setup_len),
    .strobe_len (strobe_len),
    .tail_len   (tail_len)
  );

  assign cnt_en = accept || (state_q != ST_IDLE);

  ems_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_q_n),
    .en    (cnt_en),
    .clr   (cnt_clr),
    .cnt_q (cnt_q)
  );

  ems_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .req_valid  (req_valid),
    .setup_len  (setup_len),
    .strobe_len (strobe_len),
    .tail_len   (tail_len),
    .cnt        (cnt_q),
    .state_q    (state_q),
    .accept     (accept),
    .cnt_clr    (cnt_clr),
    .capture    (capture),
    .done_q     (done)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      stretch_q <= '0;
      write_q   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else if (accept) begin
      stretch_q <= stretch_cfg;
      write_q   <= req_write;
      addr_q    <= req_addr;
      wdata_q   <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)                 rdata_q <= '0;
    else if (capture && !write_q) rdata_q <= bus_din;
  end

  always_comb begin
    req_ready   = (state_q == ST_IDLE);
    bus_ce_n    = (state_q == ST_IDLE);
    bus_rd_n    = !((state_q == ST_STROBE) && !write_q);
    bus_wr_n    = !((state_q == ST_STROBE) && write_q);
    bus_dout_oe = write_q && (state_q != ST_IDLE);
    bus_dout    = wdata_q;
    bus_addr    = addr_q;
    rdata       = rdata_q;
  end
endmodule

// File: rtl/ems_chk.sv
module ems_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ce_n,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic              bus_dout_oe
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_rd_n && bus_wr_n && bus_ce_n && !bus_dout_oe));

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> bus_wr_n);

  // R3
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> !bus_ce_n);

  // R3
  setup_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(!bus_ce_n));

  // R5
  ce_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> !bus_ce_n);

  // R6
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_dout_oe);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (req_ready || $stable(bus_addr)));
endmodule

bind ext_mem_seq ems_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .done        (done),
  .bus_addr    (bus_addr),
  .bus_ce_n    (bus_ce_n),
  .bus_rd_n    (bus_rd_n),
  .bus_wr_n    (bus_wr_n),
  .bus_dout_oe (bus_dout_oe)
);

// File: tb/sim_ext_mem_seq.sv
`timescale 1ns/1ps
module sim_ext_mem_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  stretch_cfg = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, done, bus_ce_n, bus_rd_n, bus_wr_n, bus_dout_oe;
  logic [7:0]  rdata, bus_dout;
  logic [15:0] bus_addr;
  logic [7:0]  bus_din = 8'hC3;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ext_mem_seq u0 (
    .clk(clk), .rst_n(rst_n), .stretch_cfg(stretch_cfg),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rdata(rdata),
    .bus_addr(bus_addr), .bus_ce_n(bus_ce_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe),
    .bus_din(bus_din)
  );

  // memory model: valid data only while the read strobe is low
  always @(negedge clk) bus_din <= !bus_rd_n ? (bus_addr[7:0] ^ 8'h5A) : 8'hC3;

  // {write, code[2:0], 4'b0, addr[15:0], wdata[7:0]}
  localparam logic [31:0] VEC [16] = '{
    32'h0_0_1000_00, 32'h8_0_2001_A1, 32'h1_0_1102_00, 32'h9_0_2203_B2,
    32'h2_0_1204_00, 32'hA_0_2305_C3, 32'h3_0_1306_00, 32'hB_0_2407_D4,
    32'h4_0_1408_00, 32'hC_0_2509_E5, 32'h5_0_150A_00, 32'hD_0_260B_F6,
    32'h6_0_160C_00, 32'hE_0_270D_07, 32'h7_0_170E_00, 32'hF_0_280F_18
  };

  function automatic int exp_lead(input logic [2:0] s);
    return (s == 0) ? 1 : (s <= 3) ? 2 : 10;
  endfunction
  function automatic int exp_strobe(input logic [2:0] s);
    return (s == 0) ? 2 : 4 * int'(s);
  endfunction
  function automatic int exp_tail(input logic [2:0] s);
    return (s == 0) ? 1 : (s <= 3) ? 2 : 6;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_access(input logic w, input logic [2:0] s,
                            input logic [15:0] a, input logic [7:0] d,
                            input logic [2:0] s_late, input bit hammer);
    int  n_pre = 0, n_str = 0, n_post = 0, bad_addr = 0, bad_data = 0, bad_stb = 0;
    bit  seen_str = 0, fin = 0, got_done = 0;
    logic [7:0] got_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; stretch_cfg = s; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = hammer;
    stretch_cfg = s_late;
    if (hammer) begin req_addr = ~a; req_wdata = ~d; end
    for (int i = 0; i < 80 && !fin; i++) begin
      if (i > 0) @(negedge clk);
      if (w ? !bus_rd_n : !bus_wr_n) bad_stb++;
      if (!bus_ce_n) begin
        if (bus_addr != a) bad_addr++;
        if (w && (!bus_dout_oe || bus_dout != d)) bad_data++;
        if (!w && bus_dout_oe) bad_data++;
        if (w ? !bus_wr_n : !bus_rd_n) begin n_str++; seen_str = 1; req_valid = 1'b0; end
        else if (!seen_str) n_pre++;
        else n_post++;
      end else begin
        if (!bus_rd_n || !bus_wr_n) bad_stb++;
        fin = 1; got_done = done; got_rd = rdata;
      end
    end
    chk(n_pre == exp_lead(s), "R3", "lead cycles", n_pre, exp_lead(s));
    chk(bad_addr == 0, "R3", "address mismatches", bad_addr, 0);
    chk(n_str == exp_strobe(s), (s_late != s) ? "R8" : "R4", "strobe cycles", n_str, exp_strobe(s));
    chk(n_post == exp_tail(s), "R5", "tail cycles", n_post, exp_tail(s));
    chk(bad_data == 0 && bad_stb == 0, "R6", "drive/strobe errors", bad_data + bad_stb, 0);
    chk(got_done, "R7", "done at release", int'(got_done), 1);
    if (!w) chk(got_rd == (a[7:0] ^ 8'h5A), "R7", "read data", got_rd, a[7:0] ^ 8'h5A);
    @(negedge clk);
    chk(!done, "R7", "done width", int'(done), 0);
    if (hammer) begin
      int act = 0;
      for (int i = 0; i < 5; i++) begin
        if (!bus_ce_n || !req_ready) act++;
        @(negedge clk);
      end
      chk(act == 0, "R1", "activity after ignored request", act, 0);
    end
  endtask

  initial begin
    #(20ns * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R2: reset state
    #35;
    chk(bus_rd_n && bus_wr_n && bus_ce_n && !bus_dout_oe && !done, "R2",
        "outputs in reset", int'({bus_rd_n, bus_wr_n, bus_ce_n, bus_dout_oe}), 4'b1110);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && bus_ce_n && bus_rd_n && bus_wr_n && !bus_dout_oe, "R2",
        "idle after reset", int'({req_ready, bus_ce_n, bus_dout_oe}), 3'b110);

    for (int v = 0; v < 16; v++)
      run_access(VEC[v][31], VEC[v][30:28], VEC[v][23:8], VEC[v][7:0], VEC[v][30:28], 1'b0);

    // R8: stretch change mid-access
    run_access(1'b0, 3'd1, 16'h3A3A, 8'h00, 3'd7, 1'b0);
    run_access(1'b1, 3'd6, 16'h4B4B, 8'h99, 3'd0, 1'b0);

    // R1: request held while busy is ignored
    run_access(1'b1, 3'd2, 16'h5C5C, 8'h66, 3'd2, 1'b1);

    // R9: done and next acceptance in the same cycle
    begin
      bit seen = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; stretch_cfg = 3'd0;
      req_addr = 16'h6D6D; req_wdata = 8'h12;
      for (int i = 0; i < 40 && !seen; i++) begin
        @(negedge clk);
        if (done) seen = 1;
      end
      chk(seen && req_ready, "R9", "ready with done", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!bus_ce_n && bus_wr_n, "R9", "next lead started", int'(bus_ce_n), 0);
      repeat (10) @(negedge clk);
    end

    // R2: asynchronous reset during the strobe
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; stretch_cfg = 3'd3;
    req_addr = 16'h7E7E; req_wdata = 8'h34;
    @(negedge clk); req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(!bus_wr_n, "R2", "strobe low before reset", int'(bus_wr_n), 0);
    #3 rst_n = 1'b0;
    #1;
    chk(bus_wr_n && bus_rd_n && bus_ce_n && !bus_dout_oe, "R2", "release on reset",
        int'({bus_wr_n, bus_ce_n, bus_dout_oe}), 3'b110);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_access(1'b0, 3'd0, 16'h0F0F, 8'h00, 3'd0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule